// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This unit holds the 32-bit control and status word of a SIMD floating-point execution unit. Software replaces the writable part of the word in a single cycle through a load port, and the current word can always be read on a read port. The datapath reports each completed operation as a six-bit exception event vector with a valid strobe. The unit ORs that vector into sticky flags and compares it with the per-type masks to decide whether a trap must be raised.

The rounding-mode field and a flush-to-zero request are driven straight from the register to the datapath. A load that writes nonzero data into any reserved bit is rejected as a whole and produces a one-cycle protection-fault strobe. Loading a flag that is set while its mask is clear raises no trap. A trap happens only when a later operation reports that exception type again. An unmasked underflow always traps and also suppresses the flush-to-zero request.

Top module: `simd_ctl_stat`

## Requirements
- R1: After reset the word reads 0x0000_1F80, `round_mode` is 00, and `ftz_req`, `trap_req` and `prot_fault` are all 0.
- R2: A load whose reserved bits are all zero replaces every writable bit. The new word is visible on `rd_word` in the cycle after the load. Reserved bits 31..16 and bit 6 always read 0.
- R3: A load with any of bits 31..16 or bit 6 set pulses `prot_fault` for one cycle, in the cycle after the load. Such a load leaves the word unchanged.
- R4: Flags sit in bits 5..0 in the order invalid, denormal, divide-by-zero, overflow, underflow, precision. A valid event ORs its vector into these flags. A flag is cleared only by reset or by an accepted load that writes 0 to it.
- R5: Masks sit in bits 12..7 in the same type order, and 1 means masked. In the cycle after a valid event, `trap_req` is 1 and `trap_cause` shows the event bits whose mask is 0, provided that result is nonzero. Otherwise `trap_req` is 0.
- R6: A load that leaves a flag set while its mask is clear raises no trap request.
- R7: When an accepted load and an event arrive in the same cycle, the loaded value is applied first and the event bits are ORed on top. The trap decision then uses the newly loaded masks.
- R8: `round_mode` mirrors bits 14..13: 00 is nearest-even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 rounds toward zero.
- R9: `ftz_req` is 1 only when bit 15 is 1 and the underflow mask (bit 11) is 1. An underflow event with bit 11 clear traps whether or not bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe |
| ld_word | input | 32 | Word to load |
| ev_valid | input | 1 | Operation completed with the event vector below |
| ev_flags | input | 6 | Exception types raised by the operation, lanes already ORed |
| rd_word | output | 32 | Current register value |
| round_mode | output | 2 | Rounding control to datapath |
| ftz_req | output | 1 | Flush-to-zero request to datapath |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 6 | Unmasked exception types behind the trap |
| prot_fault | output | 1 | One-cycle reserved-bit fault strobe |

## Verification
The assertions assume that `ev_flags` matters only while `ev_valid` is high. The hold check for faulting loads applies only in cycles with no event, because an event may still set flags while a rejected load is ignored. The bench changes inputs only on falling edges, so every load and event stands for exactly one rising edge. It keeps faulting loads apart from events, and in the random phase it clears reserved bits before loading.

// File: rtl/simd_csr_pkg.sv
package simd_csr_pkg;
  localparam int CSR_W   = 32;
  localparam int NTYPE   = 6;
  localparam int FLAG_LO = 0;
  localparam int MASK_LO = 7;
  localparam int RC_LO   = 13;
  localparam int RC_W    = 2;
  localparam int FTZ_BIT = 15;
  localparam int UF_IDX  = 4;
  localparam logic [CSR_W-1:0] CSR_RESET = 32'h0000_1F80;

  // Bits that a load may write; everything else is reserved.
  function automatic logic [CSR_W-1:0] writable_bits();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NTYPE; i++) begin
      m[FLAG_LO+i] = 1'b1;
      m[MASK_LO+i] = 1'b1;
    end
    for (int i = 0; i < RC_W; i++) m[RC_LO+i] = 1'b1;
    m[FTZ_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic reserved_hit(logic [CSR_W-1:0] w);
    return |(w & ~writable_bits());
  endfunction

  function automatic logic [NTYPE-1:0] unmasked(logic [NTYPE-1:0] ev,
                                                logic [NTYPE-1:0] masks);
    return ev & ~masks;
  endfunction
endpackage

// File: rtl/simd_csr_guard.sv
module simd_csr_guard
  import simd_csr_pkg::*;
(
  input  logic             ld_valid,
  input  logic [CSR_W-1:0] ld_word,
  output logic             ld_ok,
  output logic             ld_bad
);
  logic rsv_hit;
  assign rsv_hit = reserved_hit(ld_word);
  assign ld_ok   = ld_valid && !rsv_hit;
  assign ld_bad  = ld_valid &&  rsv_hit;
endmodule

// File: rtl/simd_csr_core.sv
module simd_csr_core
  import simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ok,
  input  logic [CSR_W-1:0] ld_word,
  input  logic             ev_valid,
  input  logic [NTYPE-1:0] ev_flags,
  output logic [CSR_W-1:0] csr_q,
  output logic [NTYPE-1:0] masks_nxt
);
  logic [CSR_W-1:0] base, nxt;

  always_comb begin
    base = ld_ok ? (ld_word & writable_bits()) : csr_q;
    nxt  = base;
    if (ev_valid) nxt[FLAG_LO +: NTYPE] = base[FLAG_LO +: NTYPE] | ev_flags;
  end

  assign masks_nxt = base[MASK_LO +: NTYPE];

  always_ff @(posedge clk) begin
    if (!rst_n) csr_q <= CSR_RESET;
    else        csr_q <= nxt;
  end

  // R4: without an accepted load no flag may fall
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ok |=> ((csr_q[FLAG_LO +: NTYPE] & $past(csr_q[FLAG_LO +: NTYPE]))
                == $past(csr_q[FLAG_LO +: NTYPE])));
endmodule

// File: rtl/simd_csr_trap.sv
module simd_csr_trap
  import simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [NTYPE-1:0] ev_flags,
  input  logic [NTYPE-1:0] masks_nxt,
  input  logic             ld_bad,
  output logic             trap_req,
  output logic [NTYPE-1:0] trap_cause,
  output logic             prot_fault
);
  logic [NTYPE-1:0] cause_now;
  assign cause_now = ev_valid ? unmasked(ev_flags, masks_nxt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
      prot_fault <= 1'b0;
    end else begin
      trap_req   <= |cause_now;
      trap_cause <= cause_now;
      prot_fault <= ld_bad;
    end
  end

  a_r5_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != '0));
  // R6: a trap only follows a reported event, never a load alone
  a_r6_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(ev_valid));
endmodule

// File: rtl/simd_ctl_stat.sv
module simd_ctl_stat
  import simd_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [CSR_W-1:0] ld_word,
  input  logic             ev_valid,
  input  logic [NTYPE-1:0] ev_flags,
  output logic [CSR_W-1:0] rd_word,
  output logic [RC_W-1:0]  round_mode,
  output logic             ftz_req,
  output logic             trap_req,
  output logic [NTYPE-1:0] trap_cause,
  output logic             prot_fault
);
  logic             ld_ok, ld_bad;
  logic [CSR_W-1:0] csr_q;
  logic [NTYPE-1:0] masks_nxt;

  simd_csr_guard u_guard (
    .ld_valid(ld_valid), .ld_word(ld_word), .ld_ok(ld_ok), .ld_bad(ld_bad));

  simd_csr_core u_core (
    .clk(clk), .rst_n(rst_n), .ld_ok(ld_ok), .ld_word(ld_word),
    .ev_valid(ev_valid), .ev_flags(ev_flags),
    .csr_q(csr_q), .masks_nxt(masks_nxt));

  simd_csr_trap u_trap (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_flags(ev_flags),
    .masks_nxt(masks_nxt), .ld_bad(ld_bad),
    .trap_req(trap_req), .trap_cause(trap_cause), .prot_fault(prot_fault));

  assign rd_word    = csr_q;
  assign round_mode = csr_q[RC_LO +: RC_W];
  assign ftz_req    = csr_q[FTZ_BIT] && csr_q[MASK_LO+UF_IDX];

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ok && !ev_valid) |=> (rd_word == $past(ld_word)));
  a_r3_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_bad && !ev_valid) |=> (prot_fault && $stable(rd_word)));
  a_r9_ftz_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ftz_req |-> rd_word[MASK_LO+UF_IDX]);
endmodule

// File: tb/sim_simd_ctl_stat.sv
`timescale 1ns/1ps
module sim_simd_ctl_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_word = '0;
  logic        ev_valid = 1'b0;
  logic [5:0]  ev_flags = '0;
  logic [31:0] rd_word;
  logic [1:0]  round_mode;
  logic        ftz_req, trap_req, prot_fault;
  logic [5:0]  trap_cause;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] m_word  = 32'h1F80;
  logic        m_trap  = 1'b0;
  logic [5:0]  m_cause = '0;
  logic        m_fault = 1'b0;

  always #2 clk = ~clk;

  simd_ctl_stat u0 (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rd_word",    rd_word, m_word);
    chk(tag, "round_mode", {30'd0, round_mode}, {30'd0, m_word[14:13]});
    chk(tag, "ftz_req",    {31'd0, ftz_req}, {31'd0, m_word[15] & m_word[11]});
    chk(tag, "trap_req",   {31'd0, trap_req}, {31'd0, m_trap});
    chk(tag, "trap_cause", {26'd0, trap_cause}, {26'd0, m_cause});
    chk(tag, "prot_fault", {31'd0, prot_fault}, {31'd0, m_fault});
  endtask

  // One clock: check present outputs, drive new inputs, advance model.
  task automatic step(bit ld, logic [31:0] w, bit ev, logic [5:0] f, string tag);
    logic [31:0] nxt;
    bit ok;
    @(negedge clk);
    compare(tag);
    ld_valid = ld; ld_word = w; ev_valid = ev; ev_flags = f;
    ok = ld && (w[31:16] == 16'd0) && !w[6];
    m_fault = ld && !ok;
    nxt = ok ? w : m_word;
    if (ev) begin
      nxt[5:0] = nxt[5:0] | f;
      m_cause  = f & ~nxt[12:7];
    end else m_cause = '0;
    m_trap = (m_cause != 0);
    m_word = nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    // R4 accumulation under full masking
    step(0, 0, 1, 6'h01, "R4");
    step(0, 0, 1, 6'h20, "R4");
    step(0, 0, 1, 6'h12, "R4");
    step(0, 0, 0, 0, "R4");
    step(1, 32'h0000_1F80, 0, 0, "R4");  // clears flags
    // R3 faulting loads
    step(1, 32'h0001_0000, 0, 0, "R3");
    step(1, 32'h0000_1FC0, 0, 0, "R3");
    step(0, 0, 0, 0, "R3");
    // R8 rounding encodings
    step(1, 32'h0000_3F80, 0, 0, "R8");
    step(1, 32'h0000_5F80, 0, 0, "R8");
    step(1, 32'h0000_7F80, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    // R6 divide-by-zero flag set with its mask clear: no trap
    step(1, 32'h0000_1D84, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");
    step(0, 0, 1, 6'h04, "R5");  // deferred trap fires now
    step(0, 0, 1, 6'h08, "R5");  // masked type, no trap
    step(0, 0, 0, 0, "R5");
    // R9 flush-to-zero versus unmasked underflow
    step(1, 32'h0000_9F80, 0, 0, "R9");
    step(1, 32'h0000_9780, 0, 0, "R9");
    step(0, 0, 1, 6'h10, "R9");
    step(0, 0, 0, 0, "R9");
    // R7 load and event together; invalid unmasked in new word
    step(1, 32'h0000_1F00, 1, 6'h03, "R7");
    step(0, 0, 0, 0, "R7");
    // R2 readback of a mixed word
    step(1, 32'h0000_5A3F, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    // random mix with legal loads
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = $urandom() & 32'h0000_FFBF;
      step(($urandom() % 4) == 0, w, ($urandom() % 2) == 0, 6'($urandom()), "R5");
    end
    step(0, 0, 0, 0, "R5");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule